// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a counter that climbs from zero to a ceiling, turns, and descends back to zero. It repeats this for as long as its timer clock-enable is asserted. The ceiling can be one of three fixed resolutions (255, 511 or 1023), a value written to a dedicated ceiling register, or the live compare value of channel A. Two compare channels watch the count. Each one drives a pin whose level is cleared or set on a compare hit, and the rule used depends on whether the counter is climbing or descending. The result is a PWM waveform that is centred on the ceiling.

Each channel's compare value is double-buffered. Software writes the buffer at any time, and the live value takes the buffer contents only on the tick at which the counter sits at the ceiling. So each period starts and ends at the ceiling. A ceiling change made while the counter runs therefore gives a descending slope set by the old ceiling and a climbing slope set by the new one. Sticky flags record the bottom turn, the ceiling turn and each channel's hits. Software clears a flag by writing a one to it.

The counter is a two-state machine:
- `ST_RISE`: climbing.
- `ST_FALL`: descending.

It has three transitions:
- "turn at ceiling" (`ST_RISE` to `ST_FALL`): taken on a tick with the count at or above the ceiling.
- "turn at bottom" (`ST_FALL` to `ST_RISE`): taken on a tick with the count at zero.
- "hold": taken on any cycle without a tick, in either state.

Top module: `dslope_pwm_timer`

## Requirements
- R1: On each cycle with `tick_en` high, the count steps by one toward the current ceiling while in `ST_RISE`, and toward zero while in `ST_FALL`. The ceiling value and zero are each held for exactly one tick, so the turn happens on that tick. Ceiling select values 0, 1 and 2 give ceilings 0x00FF, 0x01FF and 0x03FF. With `tick_en` low, neither the count nor the direction changes. After reset the count is 0 in `ST_RISE`.
- R2: The bottom flag is set after the tick on which the count is 0 while descending.
- R3: On the tick at which the count is at or above the ceiling while climbing, the ceiling flag is set, the direction becomes descending, and each channel's live compare value is loaded from its buffer.
- R4: A channel's match flag is set after every tick on which the count equals that channel's live compare value.
- R5: Channel mode 2 drives the waveform low on a hit while climbing and high on a hit while descending. Mode 3 does the reverse. The pin changes at the clock edge that ends the hit cycle.
- R6: A channel whose live compare value exceeds the ceiling never sees a hit, and its pin holds its level.
- R7: While a fixed ceiling is selected, a compare-buffer write keeps only the low 8, 9 or 10 bits and clears the rest.
- R8: Channel modes 0 and 1 disconnect the channel: its pin reads 0.
- R9: A channel's pin reads 0 while that channel's enable bit is 0.
- R10: Flags stay set until software writes a one to them at flag-clear address 2:
  - bit 0 clears the bottom flag;
  - bit 1 clears the ceiling flag;
  - bits 2 and 3 clear the match flags of channels A and B.
  A set event in the same cycle as a clear leaves the flag set.
- R11: Ceiling select 3 uses the ceiling register directly. Select values 4 to 7 use channel A's live compare value. A ceiling change while running shapes only the slopes that follow it.
- R12: Writes take effect at the next clock edge, whatever the level of `tick_en`. The address map is:
  - address 0 is control:
    - bits [2:0] select the ceiling;
    - bits [4:3] hold the channel A mode and bit 5 its pin enable;
    - bits [7:6] hold the channel B mode and bit 8 its pin enable.
  - address 1 is the ceiling register.
  - addresses 3 and 4 are the compare buffers of channels A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock-enable; the counter advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Present count |
| count_down | output | 1 | High while descending (`ST_FALL`) |
| pwm_out | output | 2 | Gated PWM pins, bit 0 channel A, bit 1 channel B |
| flg_bottom | output | 1 | Sticky bottom-turn flag |
| flg_top | output | 1 | Sticky ceiling-turn flag |
| flg_cmp | output | 2 | Sticky compare-hit flags, bit 0 channel A |

## Verification
Every result is due one clock edge after the cycle that causes it:
- A write shows up after the edge that samples it.
- A count step, a flag set or a pin change shows up after the edge ending the tick cycle in which the triggering count value was on the output.
- A reload at the ceiling affects hits only from the following tick onward.

The bench predicts the state after each rising edge and queues it. A monitor then compares it on the falling edge of the same cycle, so each prediction is checked exactly one edge after its cause and never straddles an edge.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    // Counter direction states
    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } slope_e;

    // Per-channel output behaviour
    typedef enum logic [1:0] {
        OM_OFF     = 2'd0,
        OM_OFF_ALT = 2'd1,
        OM_NONINV  = 2'd2,
        OM_INV     = 2'd3
    } outmode_e;

    // Register addresses
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_TOP      = 1;
    localparam int ADDR_FLAGCLR  = 2;
    localparam int ADDR_CMP_BASE = 3;

    // Ceiling select codes
    localparam logic [2:0] TS_REG = 3'd3;
    localparam logic [2:0] TS_FIXED_LIMIT = 3'd3;

endpackage

// File: rtl/dslope_cfg.sv
module dslope_cfg import dslope_pkg::*; #(
    parameter int CNT_W     = 16,
    parameter int N_CH      = 2,
    parameter int FIX_MIN_W = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [2:0]                 top_mode,
    output logic [N_CH-1:0][1:0]       out_mode,
    output logic [N_CH-1:0]            oe,
    output logic [CNT_W-1:0]           top_reg,
    output logic [CNT_W-1:0]           fix_top,
    output logic [N_CH+1:0]            flag_clr,
    output logic [N_CH-1:0]            cmp_wr,
    output logic [CNT_W-1:0]           cmp_wdata
);
    localparam int CTRL_W = 3 + 3 * N_CH;

    logic [CTRL_W-1:0] ctrl_q;
    logic              is_fixed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            top_reg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) ctrl_q  <= wr_data[CTRL_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_TOP))  top_reg <= wr_data;
        end
    end

    assign top_mode = ctrl_q[2:0];
    assign is_fixed = (top_mode < TS_FIXED_LIMIT);

    // Fixed ceiling doubles as the compare write mask
    always_comb begin
        fix_top = '1;
        for (int k = 0; k < 3; k++) begin
            if (top_mode == 3'(k)) fix_top = {CNT_W{1'b1}} >> (CNT_W - FIX_MIN_W - k);
        end
    end

    assign cmp_wdata = is_fixed ? (wr_data & fix_top) : wr_data;
    assign flag_clr  = (wr_en && wr_addr == ADDR_W'(ADDR_FLAGCLR)) ? wr_data[N_CH+1:0] : '0;

    for (genvar c = 0; c < N_CH; c++) begin : g_dec
        assign out_mode[c] = ctrl_q[3 + 3*c +: 2];
        assign oe[c]       = ctrl_q[5 + 3*c];
        assign cmp_wr[c]   = wr_en && (wr_addr == ADDR_W'(ADDR_CMP_BASE + c));
    end

endmodule

// File: rtl/dslope_counter.sv
module dslope_counter import dslope_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             falling,
    output logic             at_top,
    output logic             at_bottom
);
    slope_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= cnt_d;
        end
    end

    // Next state: turn at ceiling, turn at bottom, hold
    always_comb begin
        state_d = state_q;
        cnt_d   = count;
        if (tick) begin
            unique case (state_q)
                ST_RISE: begin
                    if (count >= top_val) begin
                        state_d = ST_FALL;
                        if (count != '0) cnt_d = count - 1'b1;
                    end else begin
                        cnt_d = count + 1'b1;
                    end
                end
                ST_FALL: begin
                    if (count == '0) begin
                        state_d = ST_RISE;
                        if (top_val != '0) cnt_d = CNT_W'(1);
                    end else begin
                        cnt_d = count - 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        falling   = (state_q == ST_FALL);
        at_top    = tick && (state_q == ST_RISE) && (count >= top_val);
        at_bottom = tick && (state_q == ST_FALL) && (count == '0);
    end

endmodule

// File: rtl/dslope_chan.sv
module dslope_chan import dslope_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] buf_data,
    input  logic [CNT_W-1:0] count,
    input  logic             falling,
    input  logic [1:0]       out_mode,
    input  logic             oe,
    output logic [CNT_W-1:0] act_val,
    output logic             hit,
    output logic             pin
);
    logic [CNT_W-1:0] buf_q;
    logic             wave_q, wave_d;
    outmode_e         om;

    assign om  = outmode_e'(out_mode);
    assign hit = tick && (count == act_val);

    always_comb begin
        wave_d = wave_q;
        if (hit) begin
            unique case (om)
                OM_OFF, OM_OFF_ALT: wave_d = wave_q;
                OM_NONINV:          wave_d = falling;
                OM_INV:             wave_d = !falling;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            act_val <= '0;
            wave_q  <= 1'b0;
        end else begin
            if (buf_wr) buf_q   <= buf_data;
            if (load)   act_val <= buf_q;
            wave_q <= wave_d;
        end
    end

    assign pin = oe && out_mode[1] && wave_q;

endmodule

// File: rtl/dslope_pwm_timer.sv
module dslope_pwm_timer import dslope_pkg::*; #(
    parameter int CNT_W     = 16,
    parameter int N_CH      = 2,
    parameter int FIX_MIN_W = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              count_down,
    output logic [N_CH-1:0]   pwm_out,
    output logic              flg_bottom,
    output logic              flg_top,
    output logic [N_CH-1:0]   flg_cmp
);
    localparam int FLG_W = N_CH + 2;

    logic [2:0]                 top_mode;
    logic [N_CH-1:0][1:0]       omode_v;
    logic [N_CH-1:0]            oe_v, cmp_wr_v, hit_v;
    logic [CNT_W-1:0]           top_reg, fix_top, cmp_wdata, top_val;
    logic [N_CH-1:0][CNT_W-1:0] act_v;
    logic [FLG_W-1:0]           flag_clr;
    logic                       at_top, at_bottom;

    dslope_cfg #(.CNT_W(CNT_W), .N_CH(N_CH), .FIX_MIN_W(FIX_MIN_W), .ADDR_W(ADDR_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .top_mode(top_mode), .out_mode(omode_v), .oe(oe_v), .top_reg(top_reg),
        .fix_top(fix_top), .flag_clr(flag_clr), .cmp_wr(cmp_wr_v), .cmp_wdata(cmp_wdata)
    );

    // Ceiling source select
    always_comb begin
        if (top_mode[2])            top_val = act_v[0];
        else if (top_mode == TS_REG) top_val = top_reg;
        else                        top_val = fix_top;
    end

    dslope_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .top_val(top_val),
        .count(count), .falling(count_down), .at_top(at_top), .at_bottom(at_bottom)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dslope_chan #(.CNT_W(CNT_W)) ch_i (
            .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(at_top),
            .buf_wr(cmp_wr_v[c]), .buf_data(cmp_wdata), .count(count),
            .falling(count_down), .out_mode(omode_v[c]), .oe(oe_v[c]),
            .act_val(act_v[c]), .hit(hit_v[c]), .pin(pwm_out[c])
        );
    end

    // Sticky flags: set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_bottom <= 1'b0;
            flg_top    <= 1'b0;
            flg_cmp    <= '0;
        end else begin
            flg_bottom <= (flg_bottom && !flag_clr[0]) || at_bottom;
            flg_top    <= (flg_top && !flag_clr[1]) || at_top;
            flg_cmp    <= (flg_cmp & ~flag_clr[FLG_W-1:2]) | hit_v;
        end
    end

endmodule

// File: rtl/dslope_pwm_timer_chk.sv
module dslope_pwm_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_en,
    input logic                       clr_top,
    input logic [CNT_W-1:0]           count,
    input logic                       count_down,
    input logic [CNT_W-1:0]           top_val,
    input logic [N_CH-1:0][CNT_W-1:0] act_v,
    input logic                       flg_bottom,
    input logic                       flg_top,
    input logic [N_CH-1:0]            flg_cmp
);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(count) && $stable(count_down)));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1) || $stable(count)));

    p_turn_bottom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count_down && count == '0) |=> !count_down);

    p_bottom_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count_down && count == '0) |=> flg_bottom);

    p_top_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !count_down && count >= top_val) |=> (flg_top && count_down));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_top && !clr_top) |=> flg_top);

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        p_match_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_en && count == act_v[c]) |=> flg_cmp[c]);
    end

endmodule

bind dslope_pwm_timer dslope_pwm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .clr_top(flag_clr[1]),
    .count(count), .count_down(count_down), .top_val(top_val), .act_v(act_v),
    .flg_bottom(flg_bottom), .flg_top(flg_top), .flg_cmp(flg_cmp)
);

// File: tb/dslope_pwm_timer_tb_top.sv
module dslope_pwm_timer_tb_top;
    localparam int CNT_W  = 16;
    localparam int N_CH   = 2;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 3 + 3 * N_CH;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  count;
    logic              count_down;
    logic [N_CH-1:0]   pwm_out;
    logic              flg_bottom, flg_top;
    logic [N_CH-1:0]   flg_cmp;

    dslope_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .count_down(count_down), .pwm_out(pwm_out),
        .flg_bottom(flg_bottom), .flg_top(flg_top), .flg_cmp(flg_cmp)
    );

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dn;
        logic [N_CH-1:0]  pwm;
        logic             fb;
        logic             ft;
        logic [N_CH-1:0]  fc;
    } obs_t;

    obs_t  q_exp[$];
    string q_ph[$];
    string phase = "";
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // Reference state, built from the requirements
    logic [CNT_W-1:0]  m_cnt, m_topreg;
    logic [CNT_W-1:0]  m_buf [N_CH];
    logic [CNT_W-1:0]  m_act [N_CH];
    logic              m_dn, m_fb, m_ft;
    logic [CTRL_W-1:0] m_ctrl;
    logic [N_CH-1:0]   m_wave, m_fc;

    function automatic logic [CNT_W-1:0] ceiling_of(input logic [2:0] sel);
        if (sel[2])      return m_act[0];
        if (sel == 3'd3) return m_topreg;
        return {CNT_W{1'b1}} >> (CNT_W - 8 - int'(sel));   // R1: 0xFF / 0x1FF / 0x3FF
    endfunction

    // Predictor: one expected item per rising edge
    always @(posedge clk) begin : pred
        logic [CNT_W-1:0] topv, mask;
        logic [N_CH-1:0]  hit;
        logic [N_CH+1:0]  clr;
        logic             up_top, dn_bot;
        obs_t             e;
        if (!rst_n) begin
            m_cnt = '0; m_topreg = '0; m_dn = 1'b0; m_fb = 1'b0; m_ft = 1'b0;
            m_ctrl = '0; m_wave = '0; m_fc = '0;
            for (int c = 0; c < N_CH; c++) begin m_buf[c] = '0; m_act[c] = '0; end
        end else begin
            topv   = ceiling_of(m_ctrl[2:0]);
            mask   = (m_ctrl[2:0] < 3'd3) ? topv : '1;
            up_top = tick_en && !m_dn && (m_cnt >= topv);
            dn_bot = tick_en && m_dn && (m_cnt == '0);
            clr    = (wr_en && wr_addr == ADDR_W'(2)) ? wr_data[N_CH+1:0] : '0;
            for (int c = 0; c < N_CH; c++) begin
                hit[c] = tick_en && (m_cnt == m_act[c]);
                if (hit[c] && m_ctrl[4+3*c]) m_wave[c] = m_dn ^ m_ctrl[3+3*c];
                m_fc[c] = (m_fc[c] && !clr[2+c]) || hit[c];
            end
            m_fb = (m_fb && !clr[0]) || dn_bot;
            m_ft = (m_ft && !clr[1]) || up_top;
            if (up_top) for (int c = 0; c < N_CH; c++) m_act[c] = m_buf[c];
            if (tick_en) begin
                if (!m_dn) begin
                    if (m_cnt >= topv) begin
                        m_dn = 1'b1;
                        if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
                    end else m_cnt = m_cnt + 1'b1;
                end else begin
                    if (m_cnt == '0) begin
                        m_dn = 1'b0;
                        if (topv != '0) m_cnt = CNT_W'(1);
                    end else m_cnt = m_cnt - 1'b1;
                end
            end
            if (wr_en) begin
                if (wr_addr == ADDR_W'(0)) m_ctrl = wr_data[CTRL_W-1:0];
                if (wr_addr == ADDR_W'(1)) m_topreg = wr_data;
                for (int c = 0; c < N_CH; c++)
                    if (wr_addr == ADDR_W'(3 + c)) m_buf[c] = wr_data & mask;
            end
        end
        e.cnt = m_cnt; e.dn = m_dn; e.fb = m_fb; e.ft = m_ft; e.fc = m_fc;
        for (int c = 0; c < N_CH; c++) e.pwm[c] = m_ctrl[5+3*c] && m_ctrl[4+3*c] && m_wave[c];
        q_exp.push_back(e);
        q_ph.push_back(phase);
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag(input string ph, input string dflt);
        return (ph == "") ? dflt : ph;
    endfunction

    // Monitor: compares on the falling edge after each prediction
    always @(negedge clk) begin : mon
        obs_t  e;
        string ph;
        if (q_exp.size() > 0) begin
            e  = q_exp.pop_front();
            ph = q_ph.pop_front();
            check(tag(ph, "R1"), "count",      32'(count),      32'(e.cnt));
            check(tag(ph, "R1"), "count_down", 32'(count_down), 32'(e.dn));
            check(tag(ph, "R2"), "flg_bottom", 32'(flg_bottom), 32'(e.fb));
            check(tag(ph, "R3"), "flg_top",    32'(flg_top),    32'(e.ft));
            check(tag(ph, "R4"), "flg_cmp",    32'(flg_cmp),    32'(e.fc));
            check(tag(ph, "R5"), "pwm_out",    32'(pwm_out),    32'(e.pwm));
        end
    end

    task automatic wr(input int a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; tick_en = 1'b1;
    endtask

    task automatic run(input int n, input int gap, input int clr_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en   = 1'b0;
            tick_en = (gap == 0) ? 1'b1 : ((i % gap) != 1);
            if ((i % clr_every) == clr_every - 1) begin
                wr_en = 1'b1; wr_addr = ADDR_W'(2); wr_data = 16'h000F;   // R10 clear all flags
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        phase = "R12";                 // reset state then register writes
        rst_n = 1'b1;
        wr(3, 16'h0040);
        phase = "R7";                  // 8-bit ceiling: upper bits dropped -> 0x80
        wr(4, 16'h1280);
        phase = "R12";
        wr(0, 16'h01F0);               // A non-inverted, B inverted, both enabled
        phase = "";
        run(1100, 0, 53);              // R1..R5 main dual-slope pattern
        phase = "R7";
        wr(3, 16'hAB20);
        run(600, 0, 53);
        phase = "";
        wr(0, 16'h01F1); wr(4, 16'h0150);
        run(1100, 0, 53);              // 9-bit ceiling
        wr(0, 16'h01F2); wr(3, 16'h0300);
        run(2100, 0, 53);              // 10-bit ceiling
        phase = "R6";
        wr(1, 16'h0100); wr(3, 16'h0180); wr(0, 16'h01F3);
        run(900, 0, 53);               // A compare above ceiling
        phase = "R11";
        wr(1, 16'h0090); run(300, 0, 53);
        wr(1, 16'h00C0); run(300, 0, 53);
        wr(3, 16'h0070); wr(4, 16'h0030); wr(0, 16'h01F4);
        run(500, 0, 53);
        wr(3, 16'h0050); run(500, 0, 53);
        phase = "R8";
        wr(0, 16'h0128);               // A mode 1, B mode 0, both enabled
        run(600, 0, 53);
        phase = "R9";
        wr(0, 16'h00D0);               // modes 2/3 with enables off
        run(600, 0, 53);
        phase = "R10";
        wr(0, 16'h01F0);
        run(1200, 3, 7);               // gapped ticks, frequent clears
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule